// File: doc/BRIEF.md
# Paged Address Translation Unit

This block widens a 16-bit processor address into a 24-bit physical address. The processor space is cut into sixteen 4 KB windows. The top nibble of the processor address picks one of sixteen mapping entries. Each entry holds a 4-bit region number, which selects one of sixteen 1 MB regions, and an 8-bit frame number, which selects a 4 KB frame inside that region. The low twelve address bits are passed through unchanged, so the block can reach 16 MB. Translation is purely combinational.

Software edits the map through four byte-wide register ports. One port latches an entry index. Two more ports read and write the frame byte and the region nibble of the selected entry. The fourth port reads back the raw index byte. A synchronous reset loads a fixed default map. That map deliberately folds several processor windows onto one physical frame. A select input, sampled only during reset, moves the monitor windows to an alternate frame.

Top module: `page_xlate_unit`

## Requirements
- R1: phys_addr[11:0] always equals cpu_addr[11:0].
- R2: phys_addr[23:12] is {region, frame} of the entry indexed by cpu_addr[15:12]. It follows cpu_addr combinationally in the same cycle.
- R3: After reset with rom_sel low, region is 1 for windows 0x0–0xE and 6 for window 0xF. The frames are 0x0E for 0x0 and 0xE, 0x01 for 0x1, and 0x02 for windows 0x2 through 0xA. Windows 0xB, 0xC and 0xD take frames 0x0B, 0x0C and 0x0D, and window 0xF takes frame 0x00.
- R4: After reset with rom_sel high, windows 0x0 and 0xE use frame 0x10. Every other entry is as in R3.
- R5: A write to port 0 stores the full byte, and its low four bits become the entry index. A read of port 0 returns the index zero-extended. A read of port 3 returns the stored byte unchanged. The index resets to 0x00.
- R6: Port 1 writes and reads the frame byte of the indexed entry.
- R7: A write to port 2 loads wdata[3:0] into the region of the indexed entry. A read of port 2 returns {4'b0000, region}.
- R8: A write to port 3 has no effect on the index or on any entry.
- R9: Every cycle with reg_req high produces reg_ack high in the next cycle, with reg_rdata valid. reg_ack is low in every other cycle.
- R10: An entry write is reflected at phys_addr in the cycle where its acknowledge is high.
- R11: A change of rom_sel after reset does not alter the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the default map |
| rom_sel | input | 1 | Chooses the alternate monitor frame; sampled only during reset |
| cpu_addr | input | 16 | Processor address |
| phys_addr | output | 24 | Translated physical address |
| reg_req | input | 1 | One register transfer per high cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_port | input | 2 | Register port number 0–3 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_ack is high |
| reg_ack | output | 1 | Transfer acknowledge, one cycle after reg_req |

## Verification
A wrong map entry shows at phys_addr the moment a processor address falls in that window. No clock edge is needed, so each default entry is checked by sweeping all sixteen windows. A corrupted index or stray write shows up in the acknowledge cycle of the next read of ports 0, 1, 2 or 3. It also shows up as a changed translation of the affected window. Aliased windows are checked one by one, so a write that spills into a neighbour entry is exposed immediately.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int REGION_W = 4;
    localparam int FRAME_W  = 8;

    localparam logic [REGION_W-1:0] REG_SRAM  = 4'h1;
    localparam logic [REGION_W-1:0] REG_VIDEO = 4'h6;
    localparam logic [FRAME_W-1:0]  MON_STD   = 8'h0E;
    localparam logic [FRAME_W-1:0]  MON_ALT   = 8'h10;
    localparam logic [FRAME_W-1:0]  FOLD_FRM  = 8'h02;

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_FRAME  = 2'd1,
        PORT_REGION = 2'd2,
        PORT_RAW    = 2'd3
    } port_e;

    // Default region for a processor window
    function automatic logic [REGION_W-1:0] dflt_region(input logic [3:0] win);
        return (win == 4'hF) ? REG_VIDEO : REG_SRAM;
    endfunction

    // Default frame for a processor window; windows 2..A fold onto one frame
    function automatic logic [FRAME_W-1:0] dflt_frame(input logic [3:0] win, input logic alt);
        logic [FRAME_W-1:0] f;
        if (win == 4'h0 || win == 4'hE)
            f = alt ? MON_ALT : MON_STD;
        else if (win == 4'hF)
            f = '0;
        else if (win >= 4'h2 && win <= 4'hA)
            f = FOLD_FRM;
        else
            f = {4'h0, win};
        return f;
    endfunction
endpackage

// File: rtl/xlate_regfile.sv
module xlate_regfile #(
    parameter int NENT  = 16,
    parameter int RW    = xlate_pkg::REGION_W,
    parameter int FW    = xlate_pkg::FRAME_W,
    parameter int BYTEW = 8,
    localparam int IDXW = $clog2(NENT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rom_sel,
    input  logic                     wr_en,
    input  logic [1:0]               wr_port,
    input  logic [BYTEW-1:0]         wr_data,
    output logic [NENT-1:0][RW-1:0]  region_tab,
    output logic [NENT-1:0][FW-1:0]  frame_tab,
    output logic [BYTEW-1:0]         idx_raw,
    output logic [RW-1:0]            sel_region,
    output logic [FW-1:0]            sel_frame
);
    import xlate_pkg::*;

    typedef struct packed {
        logic [BYTEW-1:0]        idx;
        logic [NENT-1:0][RW-1:0] region;
        logic [NENT-1:0][FW-1:0] frame;
    } map_st_t;

    map_st_t st_d, st_q;
    logic [IDXW-1:0] cur_idx;

    assign cur_idx = st_q.idx[IDXW-1:0];

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.idx = '0;
            for (int i = 0; i < NENT; i++) begin
                st_d.region[i] = RW'(dflt_region(4'(i)));
                st_d.frame[i]  = FW'(dflt_frame(4'(i), rom_sel));
            end
        end else if (wr_en) begin
            case (port_e'(wr_port))
                PORT_INDEX:  st_d.idx = wr_data;
                PORT_FRAME:  st_d.frame[cur_idx]  = wr_data[FW-1:0];
                PORT_REGION: st_d.region[cur_idx] = wr_data[RW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign region_tab = st_q.region;
    assign frame_tab  = st_q.frame;
    assign idx_raw    = st_q.idx;
    assign sel_region = st_q.region[cur_idx];
    assign sel_frame  = st_q.frame[cur_idx];
endmodule

// File: rtl/xlate_busif.sv
module xlate_busif #(
    parameter int RW    = xlate_pkg::REGION_W,
    parameter int FW    = xlate_pkg::FRAME_W,
    parameter int BYTEW = 8,
    parameter int IDXW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  logic [1:0]       port,
    input  logic [BYTEW-1:0] idx_raw,
    input  logic [RW-1:0]    sel_region,
    input  logic [FW-1:0]    sel_frame,
    output logic             wr_en,
    output logic             ack,
    output logic [BYTEW-1:0] rdata
);
    import xlate_pkg::*;

    typedef struct packed {
        logic             ack;
        logic [BYTEW-1:0] rdata;
    } bus_st_t;

    bus_st_t bs_d, bs_q;
    logic [BYTEW-1:0] mux_rd;

    assign wr_en = req & we;

    always_comb begin
        case (port_e'(port))
            PORT_INDEX:  mux_rd = BYTEW'(idx_raw[IDXW-1:0]);
            PORT_FRAME:  mux_rd = BYTEW'(sel_frame);
            PORT_REGION: mux_rd = BYTEW'(sel_region);
            default:     mux_rd = idx_raw;
        endcase
    end

    always_comb begin
        bs_d = bs_q;
        if (rst) begin
            bs_d = '0;
        end else begin
            bs_d.ack = req;
            if (req && !we)
                bs_d.rdata = mux_rd;
        end
    end

    always_ff @(posedge clk) begin
        bs_q <= bs_d;
    end

    assign ack   = bs_q.ack;
    assign rdata = bs_q.rdata;
endmodule

// File: rtl/xlate_mapper.sv
module xlate_mapper #(
    parameter int NENT = 16,
    parameter int RW   = xlate_pkg::REGION_W,
    parameter int FW   = xlate_pkg::FRAME_W,
    parameter int OFFW = 12,
    localparam int IDXW = $clog2(NENT),
    localparam int INW  = IDXW + OFFW,
    localparam int OUTW = RW + FW + OFFW
) (
    input  logic [INW-1:0]            vaddr,
    input  logic [NENT-1:0][RW-1:0]   region_tab,
    input  logic [NENT-1:0][FW-1:0]   frame_tab,
    output logic [OUTW-1:0]           paddr
);
    logic [IDXW-1:0] win;

    assign win   = vaddr[INW-1:OFFW];
    assign paddr = {region_tab[win], frame_tab[win], vaddr[OFFW-1:0]};
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
    parameter int NENT  = 16,
    parameter int RW    = xlate_pkg::REGION_W,
    parameter int FW    = xlate_pkg::FRAME_W,
    parameter int OFFW  = 12,
    parameter int BYTEW = 8,
    localparam int IDXW = $clog2(NENT),
    localparam int INW  = IDXW + OFFW,
    localparam int OUTW = RW + FW + OFFW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rom_sel,
    input  logic [INW-1:0]   cpu_addr,
    output logic [OUTW-1:0]  phys_addr,
    input  logic             reg_req,
    input  logic             reg_we,
    input  logic [1:0]       reg_port,
    input  logic [BYTEW-1:0] reg_wdata,
    output logic [BYTEW-1:0] reg_rdata,
    output logic             reg_ack
);
    logic [NENT-1:0][RW-1:0] region_tab;
    logic [NENT-1:0][FW-1:0] frame_tab;
    logic [BYTEW-1:0]        idx_raw;
    logic [RW-1:0]           sel_region;
    logic [FW-1:0]           sel_frame;
    logic                    wr_en;

    xlate_regfile #(.NENT(NENT), .RW(RW), .FW(FW), .BYTEW(BYTEW)) u_regs (
        .clk(clk), .rst(rst), .rom_sel(rom_sel),
        .wr_en(wr_en), .wr_port(reg_port), .wr_data(reg_wdata),
        .region_tab(region_tab), .frame_tab(frame_tab), .idx_raw(idx_raw),
        .sel_region(sel_region), .sel_frame(sel_frame)
    );

    xlate_busif #(.RW(RW), .FW(FW), .BYTEW(BYTEW), .IDXW(IDXW)) u_bus (
        .clk(clk), .rst(rst), .req(reg_req), .we(reg_we), .port(reg_port),
        .idx_raw(idx_raw), .sel_region(sel_region), .sel_frame(sel_frame),
        .wr_en(wr_en), .ack(reg_ack), .rdata(reg_rdata)
    );

    xlate_mapper #(.NENT(NENT), .RW(RW), .FW(FW), .OFFW(OFFW)) u_map (
        .vaddr(cpu_addr), .region_tab(region_tab), .frame_tab(frame_tab),
        .paddr(phys_addr)
    );
endmodule

// File: rtl/xlate_checks.sv
module xlate_checks (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [23:0] phys_addr,
    input logic        reg_req,
    input logic        reg_we,
    input logic [1:0]  reg_port,
    input logic        reg_ack
);
    // R1: offset bits pass through
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        phys_addr[11:0] == cpu_addr[11:0]);

    // R9: every request acknowledged next cycle
    assert_ack_follows_R9: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> reg_ack);

    // R9: no acknowledge without a request
    assert_no_spurious_ack_R9: assert property (@(posedge clk) disable iff (rst)
        !reg_req |=> !reg_ack);

    // R8: writes to the raw port leave translation unchanged
    assert_raw_write_inert_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_port == 2'd3) |=>
            (cpu_addr != $past(cpu_addr) || phys_addr == $past(phys_addr)));

    // R11: without register traffic the map is frozen, whatever rom_sel does
    assert_map_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        !reg_req |=> (cpu_addr != $past(cpu_addr) || phys_addr == $past(phys_addr)));

    // R3: folded window 7 lands on the shared frame right after reset
    assert_fold_default_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && cpu_addr[15:12] == 4'h7) |-> phys_addr[23:12] == 12'h102);
endmodule

bind page_xlate_unit xlate_checks u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .reg_req(reg_req), .reg_we(reg_we), .reg_port(reg_port), .reg_ack(reg_ack)
);

// File: tb/page_xlate_unit_tb.sv
module page_xlate_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // {cpu_addr, expected phys_addr} for the default map, rom_sel low (R3, R1, R2)
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h0123, 24'h10E123}, {16'h1FFF, 24'h101FFF}, {16'h2000, 24'h102000},
        {16'h3ABC, 24'h102ABC}, {16'h4001, 24'h102001}, {16'h5555, 24'h102555},
        {16'h6AAA, 24'h102AAA}, {16'h7800, 24'h102800}, {16'h8FFE, 24'h102FFE},
        {16'h9123, 24'h102123}, {16'hA7FF, 24'h1027FF}, {16'hB010, 24'h10B010},
        {16'hC00C, 24'h10C00C}, {16'hD0D0, 24'h10D0D0}, {16'hE000, 24'h10E000},
        {16'hF780, 24'h600780}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        rom_sel = 0;
    logic [15:0] cpu_addr = '0;
    logic [23:0] phys_addr;
    logic        reg_req = 0;
    logic        reg_we = 0;
    logic [1:0]  reg_port = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        reg_ack;
    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_unit u_dut (
        .clk(clk), .rst(rst), .rom_sel(rom_sel), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .reg_req(reg_req), .reg_we(reg_we),
        .reg_port(reg_port), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst = 1; rom_sel = sel; reg_req = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic xfer(input logic [1:0] p, input logic w, input logic [7:0] d,
                        output logic [7:0] r);
        @(negedge clk);
        reg_req = 1; reg_we = w; reg_port = p; reg_wdata = d;
        @(posedge clk); #1;
        chk("R9 ack", {31'b0, reg_ack}, 32'd1);
        r = reg_rdata;
        @(negedge clk);
        reg_req = 0; reg_we = 0;
    endtask

    task automatic xlate(input string req, input logic [15:0] a, input logic [23:0] e);
        cpu_addr = a; #1;
        chk(req, {8'b0, phys_addr}, {8'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        do_reset(1'b0);
        #1;
        chk("R9 ack low after reset", {31'b0, reg_ack}, 32'd0);

        // Table walk of default map
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            xlate("R3 default map", VEC[i][39:24], VEC[i][23:0]);
            chk("R1 offset", {20'b0, phys_addr[11:0]}, {20'b0, VEC[i][35:24]});
        end

        // Reset index reads
        xfer(2'd0, 0, 8'h00, rd); chk("R5 index reset", {24'b0, rd}, 32'h00);
        xfer(2'd1, 0, 8'h00, rd); chk("R6 frame of entry 0", {24'b0, rd}, 32'h0E);

        // Index write
        xfer(2'd0, 1, 8'hA5, rd);
        xfer(2'd0, 0, 8'h00, rd); chk("R5 index read", {24'b0, rd}, 32'h05);
        xfer(2'd3, 0, 8'h00, rd); chk("R5 raw read", {24'b0, rd}, 32'hA5);

        // Frame write, visible in ack cycle
        cpu_addr = 16'h5123;
        @(negedge clk);
        reg_req = 1; reg_we = 1; reg_port = 2'd1; reg_wdata = 8'h3C;
        @(posedge clk); #1;
        chk("R9 ack on write", {31'b0, reg_ack}, 32'd1);
        chk("R10 frame visible in ack cycle", {8'b0, phys_addr}, 32'h13C123);
        @(negedge clk); reg_req = 0; reg_we = 0;

        xfer(2'd2, 1, 8'hF7, rd);
        @(negedge clk);
        xlate("R2 rewritten entry", 16'h5123, 24'h73C123);
        xfer(2'd1, 0, 8'h00, rd); chk("R6 frame read", {24'b0, rd}, 32'h3C);
        xfer(2'd2, 0, 8'h00, rd); chk("R7 region read upper zero", {24'b0, rd}, 32'h07);
        @(negedge clk);
        xlate("R2 alias neighbour untouched", 16'h4123, 24'h102123);

        // Raw port write ignored
        xfer(2'd3, 1, 8'h00, rd);
        xfer(2'd3, 0, 8'h00, rd); chk("R8 raw unchanged", {24'b0, rd}, 32'hA5);
        xfer(2'd0, 0, 8'h00, rd); chk("R8 index unchanged", {24'b0, rd}, 32'h05);
        xfer(2'd1, 0, 8'h00, rd); chk("R8 frame unchanged", {24'b0, rd}, 32'h3C);
        @(negedge clk);
        xlate("R8 translation unchanged", 16'h5123, 24'h73C123);

        // Ack drops after single request
        @(posedge clk); #1;
        chk("R9 ack low idle", {31'b0, reg_ack}, 32'd0);

        // rom_sel change after reset
        @(negedge clk); rom_sel = 1;
        repeat (3) @(negedge clk);
        xlate("R11 rom_sel ignored", 16'h0000, 24'h10E000);
        xlate("R11 rom_sel ignored E", 16'hE456, 24'h10E456);

        // Alternate monitor frame
        do_reset(1'b1);
        @(negedge clk);
        xlate("R4 window 0 alt", 16'h0000, 24'h110000);
        xlate("R4 window E alt", 16'hEFFF, 24'h110FFF);
        xlate("R4 window 1 unchanged", 16'h1000, 24'h101000);
        xlate("R4 window F unchanged", 16'hF001, 24'h600001);
        xlate("R4 fold unchanged", 16'hA000, 24'h102000);

        report();
    end
endmodule